// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for 128 pins, grouped as four banks of 32. Each pin carries a direction bit, an output latch, a synchronised input level, rising and falling edge-detect enables and a sticky edge-status bit. Each bank also holds two alternate-function words. The block stores these words and has no other use for them. Software reaches all of this state through a single-cycle register bus. Pin levels and output latches are updated through separate set and clear registers, so no read-modify-write is needed.

Edge events raise interrupts. Status bit 0 and status bit 1 of bank 0 each drive a dedicated line. Every other status bit in all banks is ORed onto a third, shared line. While the processor reports that it is halted, a change on an input pin that belongs to a fixed per-bank wake mask produces a one-cycle wake request. Each read of a level register also produces a one-cycle notify strobe.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous reset, every direction, latch, enable, status and alternate-function word is zero. `pin_out`, all three interrupt lines, `wake_req`, `level_rd_strobe` and `bus_rdata` are low.
- R2: Kinds 0 to 6 are level, direction, set, clear, rising enable, falling enable and status. Kind k of banks 0 to 2 is at offset 12*k + 4*bank. Kind k of bank 3 is at 0x100 + 12*k. Any other offset below 0x200, including an offset that is not word-aligned, reads zero and ignores writes.
- R3: A level read returns the latch bit for pins whose direction bit is 1. It returns the input level for pins whose direction bit is 0. A pin change appears in the input level three clock edges after it is applied: two synchroniser stages, then the level register.
- R4: A write to the set register ORs the data into the latch. A write to the clear register clears each latch bit where the data is 1. Both registers read as zero.
- R5: `pin_out` for each pin equals its latch bit ANDed with its direction bit.
- R6: A status bit is set when the input level goes 0 to 1 and the rising enable is set, or goes 1 to 0 and the falling enable is set. This happens only while the pin's direction bit is 0.
- R7: A status bit stays set until software writes 1 to it. Writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the new edge wins.
- R8: `irq_p0` follows status bit 0 of bank 0. `irq_p1` follows status bit 1 of bank 0. `irq_rest` is the OR of every other status bit in all four banks.
- R9: `wake_req` pulses for one cycle when `halted` is high and an input-direction pin changes level, provided that pin is in the wake mask. The masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R10: An offset of 0x200 or more is ignored: a write there changes nothing and a read there returns zero.
- R11: `level_rd_strobe` is high for exactly the one cycle in which the data of a level-register read is presented.
- R12: Read data is registered and is valid on the cycle after `bus_rd`. In cycles with no read, `bus_rdata` is zero. A write takes effect at the edge on which it is sampled.
- R13: Each bank has a low alternate-function word and a high one. Bank b's low word is at 0x054 + 8*b and its high word is at 0x058 + 8*b. Both are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | 128 | Raw asynchronous pin inputs |
| pin_out | output | 128 | Driven pin levels |
| halted | input | 1 | Processor halted, enables wake requests |
| irq_p0 | output | 1 | Interrupt for status bit 0 of bank 0 |
| irq_p1 | output | 1 | Interrupt for status bit 1 of bank 0 |
| irq_rest | output | 1 | Interrupt for all other status bits |
| wake_req | output | 1 | One-cycle wake request |
| level_rd_strobe | output | 1 | Marks the data cycle of a level read |

## Verification
Each result has its own latency. Read data and the level strobe appear one cycle after the request. A write is visible to outputs and reads on the next cycle. A pin change reaches the input level, the status bits, the interrupt lines and the wake pulse on the third rising edge after it is driven. The bench drives and samples on falling edges. A behavioural model advances on every rising edge and is compared against all outputs on every falling edge, so each result is checked in exactly the cycle it becomes due. Directed sequences wait a fixed four cycles after a pin change before reading, which covers the three-edge latency with margin.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int NBANK   = 4;
  localparam int BW      = 32;
  localparam int BANK_IW = $clog2(NBANK);

  // Kinds 0..6 keep the numeric order used by the offset formula.
  typedef enum logic [3:0] {
    K_LEVEL = 4'd0,
    K_DIR   = 4'd1,
    K_SET   = 4'd2,
    K_CLR   = 4'd3,
    K_RISE  = 4'd4,
    K_FALL  = 4'd5,
    K_STAT  = 4'd6,
    K_AFLO  = 4'd7,
    K_AFHI  = 4'd8,
    K_NONE  = 4'd15
  } reg_kind_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 128,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]  addr,
  output reg_kind_t          kind,
  output logic [BANK_IW-1:0] bank
);
  logic [7:0] lo;
  logic [2:0] idx;

  assign lo = addr[7:0];

  always_comb begin
    kind = K_NONE;
    bank = '0;
    idx  = 3'((lo - 8'h54) >> 2);
    if (addr[ADDR_W-1:9] == '0 && addr[1:0] == 2'b00) begin
      if (addr[8]) begin
        if (lo < 8'h54 && (lo % 8'd12) == 8'd0) begin
          kind = reg_kind_t'(4'(lo / 8'd12));
          bank = BANK_IW'(3);
        end
      end else if (lo < 8'h54) begin
        kind = reg_kind_t'(4'(lo / 8'd12));
        bank = BANK_IW'((lo % 8'd12) >> 2);
      end else if (lo <= 8'h70) begin
        bank = BANK_IW'(idx[2:1]);
        kind = idx[0] ? K_AFHI : K_AFLO;
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int          W     = 32,
  parameter logic [W-1:0] WMASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  reg_kind_t    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sin,
  input  logic         halted,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] aflo_q,
  output logic [W-1:0] afhi_q,
  output logic         wake_hit
);
  logic [W-1:0] chg, hits, clr;

  assign chg      = sin ^ lvl_q;
  assign hits     = chg & ~dir_q & ((sin & rise_q) | (~sin & fall_q));
  assign clr      = (we && kind == K_STAT) ? wdata : '0;
  assign wake_hit = halted && |(chg & ~dir_q & WMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      lat_q  <= '0;
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      aflo_q <= '0;
      afhi_q <= '0;
    end else begin
      lvl_q  <= sin;
      stat_q <= (stat_q & ~clr) | hits;
      if (we) begin
        case (kind)
          K_DIR:  dir_q  <= wdata;
          K_SET:  lat_q  <= lat_q | wdata;
          K_CLR:  lat_q  <= lat_q & ~wdata;
          K_RISE: rise_q <= wdata;
          K_FALL: fall_q <= wdata;
          K_AFLO: aflo_q <= wdata;
          K_AFHI: afhi_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assert_set_or_R4: assert property (@(posedge clk) disable iff (rst)
    (we && kind == K_SET) |=> lat_q == ($past(lat_q) | $past(wdata)));

  assert_no_out_edge_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_q & ~$past(stat_q) & $past(dir_q)) == '0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !(we && kind == K_STAT) |=> (stat_q & $past(stat_q)) == $past(stat_q));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (we && kind == K_STAT && hits == '0) |=> stat_q == ($past(stat_q) & ~$past(wdata)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter logic [NBANK*BW-1:0] WAKE_MASK =
    {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BW-1:0]       bus_wdata,
  output logic [BW-1:0]       bus_rdata,
  input  logic [NBANK*BW-1:0] pin_in,
  output logic [NBANK*BW-1:0] pin_out,
  input  logic                halted,
  output logic                irq_p0,
  output logic                irq_p1,
  output logic                irq_rest,
  output logic                wake_req,
  output logic                level_rd_strobe
);
  localparam int NPIN = NBANK * BW;

  logic [NPIN-1:0]    pin_sync;
  reg_kind_t          dec_kind;
  logic [BANK_IW-1:0] dec_bank;
  logic [BW-1:0] dir_a [NBANK];
  logic [BW-1:0] lat_a [NBANK];
  logic [BW-1:0] lvl_a [NBANK];
  logic [BW-1:0] rise_a[NBANK];
  logic [BW-1:0] fall_a[NBANK];
  logic [BW-1:0] stat_a[NBANK];
  logic [BW-1:0] aflo_a[NBANK];
  logic [BW-1:0] afhi_a[NBANK];
  logic [NBANK-1:0] wake_hit;
  logic [BW-1:0] rd_val;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .kind(dec_kind), .bank(dec_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gpio_bank #(.W(BW), .WMASK(WAKE_MASK[b*BW +: BW])) u_bank (
      .clk(clk), .rst(rst),
      .we(bus_wr && dec_kind != K_NONE && dec_bank == BANK_IW'(b)),
      .kind(dec_kind), .wdata(bus_wdata),
      .sin(pin_sync[b*BW +: BW]), .halted(halted),
      .dir_q(dir_a[b]), .lat_q(lat_a[b]), .lvl_q(lvl_a[b]),
      .rise_q(rise_a[b]), .fall_q(fall_a[b]), .stat_q(stat_a[b]),
      .aflo_q(aflo_a[b]), .afhi_q(afhi_a[b]), .wake_hit(wake_hit[b])
    );
    assign pin_out[b*BW +: BW] = lat_a[b] & dir_a[b];
  end

  always_comb begin
    case (dec_kind)
      K_LEVEL: rd_val = (lat_a[dec_bank] & dir_a[dec_bank]) |
                        (lvl_a[dec_bank] & ~dir_a[dec_bank]);
      K_DIR:   rd_val = dir_a[dec_bank];
      K_RISE:  rd_val = rise_a[dec_bank];
      K_FALL:  rd_val = fall_a[dec_bank];
      K_STAT:  rd_val = stat_a[dec_bank];
      K_AFLO:  rd_val = aflo_a[dec_bank];
      K_AFHI:  rd_val = afhi_a[dec_bank];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata       <= '0;
      level_rd_strobe <= 1'b0;
      wake_req        <= 1'b0;
    end else begin
      bus_rdata       <= bus_rd ? rd_val : '0;
      level_rd_strobe <= bus_rd && dec_kind == K_LEVEL;
      wake_req        <= |wake_hit;
    end
  end

  always_comb begin
    irq_rest = |(stat_a[0] & ~BW'(3));
    for (int b = 1; b < NBANK; b++) irq_rest = irq_rest | (|stat_a[b]);
  end

  assign irq_p0 = stat_a[0][0];
  assign irq_p1 = stat_a[0][1];

  assert_oob_read_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[ADDR_W-1:9] != '0) |=> bus_rdata == '0);

  assert_strobe_src_R11: assert property (@(posedge clk) disable iff (rst)
    level_rd_strobe |-> $past(bus_rd));

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out;
  logic         halted = 1'b0;
  logic         irq_p0, irq_p1, irq_rest, wake_req, level_rd_strobe;

  int total = 0, bad = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .halted(halted),
    .irq_p0(irq_p0), .irq_p1(irq_p1), .irq_rest(irq_rest),
    .wake_req(wake_req), .level_rd_strobe(level_rd_strobe)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offset of kind k (0..8) in bank b, taken from R2 and R13.
  function automatic logic [9:0] addr_of(input int k, input int b);
    if (k <= 6) return (b < 3) ? 10'(k * 12 + b * 4) : 10'(256 + k * 12);
    else if (k == 7) return 10'(84 + b * 8);
    else return 10'(88 + b * 8);
  endfunction

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] WM [4] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};
  logic [31:0] m_dir[4], m_lat[4], m_il[4], m_s1[4], m_s2[4];
  logic [31:0] m_re[4], m_fe[4], m_st[4], m_lo[4], m_hi[4];
  logic [31:0] m_rdata;
  logic        m_stb, m_wake;

  always @(posedge clk) begin : model
    int k, b;
    bit ok, wk;
    logic [31:0] ch, hit, cl;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_dir[i] = 0; m_lat[i] = 0; m_il[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
        m_re[i] = 0; m_fe[i] = 0; m_st[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
      end
      m_rdata = 0; m_stb = 0; m_wake = 0;
    end else begin
      ok = 0; k = 0; b = 0;
      for (int kk = 0; kk < 9; kk++)
        for (int bb = 0; bb < 4; bb++)
          if (bus_addr == addr_of(kk, bb)) begin ok = 1; k = kk; b = bb; end
      m_rdata = 0; m_stb = 0;
      if (bus_rd && ok) begin
        case (k)
          0: begin m_rdata = (m_lat[b] & m_dir[b]) | (m_il[b] & ~m_dir[b]); m_stb = 1; end
          1: m_rdata = m_dir[b];
          4: m_rdata = m_re[b];
          5: m_rdata = m_fe[b];
          6: m_rdata = m_st[b];
          7: m_rdata = m_lo[b];
          8: m_rdata = m_hi[b];
          default: m_rdata = 0;
        endcase
      end
      wk = 0;
      for (int bb = 0; bb < 4; bb++) begin
        ch  = m_s2[bb] ^ m_il[bb];
        hit = ch & ~m_dir[bb] & ((m_s2[bb] & m_re[bb]) | (~m_s2[bb] & m_fe[bb]));
        cl  = (bus_wr && ok && k == 6 && b == bb) ? bus_wdata : 32'h0;
        m_st[bb] = (m_st[bb] & ~cl) | hit;
        if (halted && ((ch & ~m_dir[bb] & WM[bb]) != 0)) wk = 1;
      end
      if (bus_wr && ok) begin
        case (k)
          1: m_dir[b] = bus_wdata;
          2: m_lat[b] = m_lat[b] | bus_wdata;
          3: m_lat[b] = m_lat[b] & ~bus_wdata;
          4: m_re[b]  = bus_wdata;
          5: m_fe[b]  = bus_wdata;
          7: m_lo[b]  = bus_wdata;
          8: m_hi[b]  = bus_wdata;
          default: ;
        endcase
      end
      for (int bb = 0; bb < 4; bb++) begin
        m_il[bb] = m_s2[bb];
        m_s2[bb] = m_s1[bb];
        m_s1[bb] = pin_in[bb*32 +: 32];
      end
      m_wake = wk;
    end
  end

  always @(negedge clk) begin : compare
    logic [127:0] eo;
    logic er;
    if (!rst && cmp_on) begin
      er = (m_st[0][31:2] != 0) || (m_st[1] != 0) || (m_st[2] != 0) || (m_st[3] != 0);
      for (int bb = 0; bb < 4; bb++) eo[bb*32 +: 32] = m_lat[bb] & m_dir[bb];
      chk("R5 pin_out", pin_out, eo);
      chk("R8 irq_p0", 128'(irq_p0), 128'(m_st[0][0]));
      chk("R8 irq_p1", 128'(irq_p1), 128'(m_st[0][1]));
      chk("R8 irq_rest", 128'(irq_rest), 128'(er));
      chk("R9 wake_req", 128'(wake_req), 128'(m_wake));
      chk("R11 strobe", 128'(level_rd_strobe), 128'(m_stb));
      chk("R12 rdata", 128'(bus_rdata), 128'(m_rdata));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic s);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; s = level_rd_strobe;
    bus_rd = 0;
  endtask

  task automatic rd_exp(input string tag, input logic [9:0] a, input logic [31:0] e);
    logic [31:0] d;
    logic s;
    rd(a, d, s);
    chk(tag, 128'(d), 128'(e));
  endtask

  task automatic wake_count(output int n);
    n = 0;
    repeat (6) begin
      @(negedge clk);
      n += int'(wake_req);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic s;
    int n;
    repeat (5) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", pin_out, 128'h0);
    chk("R1 irqs", 128'({irq_p0, irq_p1, irq_rest, wake_req}), 128'h0);
    rd_exp("R1 dir0", 10'h00C, 32'h0);
    rd_exp("R1 stat3", 10'h148, 32'h0);
    // R4 set/clear and R5 pin drive
    wr(10'h00C, 32'hFFFF0000);
    wr(10'h018, 32'h00FFFF00);
    rd_exp("R4 level after set", 10'h000, 32'h00FF0000);
    rd_exp("R4 set reads zero", 10'h018, 32'h0);
    wr(10'h024, 32'h000F0000);
    rd_exp("R4 level after clear", 10'h000, 32'h00F00000);
    rd_exp("R4 clear reads zero", 10'h024, 32'h0);
    chk("R5 pin_out bank0", 128'(pin_out[31:0]), 128'h00F00000);
    // R2 interleaved map, misaligned access
    wr(10'h10C, 32'h12345678);
    wr(10'h014, 32'h0000ABCD);
    rd_exp("R2 dir3", 10'h10C, 32'h12345678);
    rd_exp("R2 dir2", 10'h014, 32'h0000ABCD);
    rd_exp("R2 dir1", 10'h010, 32'h0);
    wr(10'h00D, 32'hFFFFFFFF);
    rd_exp("R2 misaligned", 10'h00D, 32'h0);
    rd_exp("R2 dir0 kept", 10'h00C, 32'hFFFF0000);
    // R13 alternate-function words
    wr(10'h05C, 32'hA5A50001);
    wr(10'h070, 32'h0000BEEF);
    rd_exp("R13 bank1 low", 10'h05C, 32'hA5A50001);
    rd_exp("R13 bank1 high", 10'h060, 32'h0);
    rd_exp("R13 bank3 high", 10'h070, 32'h0000BEEF);
    rd_exp("R13 bank3 low", 10'h06C, 32'h0);
    // R3 level mux and synchroniser latency
    pin_in[3:0] = 4'hF;
    pin_in[31]  = 1'b1;
    repeat (4) @(negedge clk);
    rd_exp("R3 level mix", 10'h000, 32'h00F0000F);
    // R6 edge detection, output pins excluded
    wr(10'h130, 32'h1);
    wr(10'h030, 32'h80000000);
    pin_in[31] = 1'b0;
    repeat (4) @(negedge clk);
    pin_in[31] = 1'b1;
    pin_in[96] = 1'b1;
    repeat (4) @(negedge clk);
    rd_exp("R6 rising input", 10'h148, 32'h1);
    rd_exp("R6 output pin no edge", 10'h048, 32'h0);
    chk("R8 irq_rest from bank3", 128'(irq_rest), 128'h1);
    pin_in[96] = 1'b0;
    repeat (4) @(negedge clk);
    rd_exp("R7 sticky", 10'h148, 32'h1);
    // R7 write-one-to-clear
    wr(10'h148, 32'h0);
    rd_exp("R7 write zero keeps", 10'h148, 32'h1);
    wr(10'h148, 32'h1);
    rd_exp("R7 write one clears", 10'h148, 32'h0);
    chk("R8 irq_rest cleared", 128'(irq_rest), 128'h0);
    // R8 dedicated interrupt lines
    wr(10'h03C, 32'h3);
    pin_in[1:0] = 2'b00;
    repeat (4) @(negedge clk);
    chk("R8 dedicated lines", 128'({irq_p0, irq_p1, irq_rest}), 128'b110);
    wr(10'h048, 32'h1);
    chk("R7 partial clear", 128'({irq_p0, irq_p1}), 128'b01);
    wr(10'h048, 32'h2);
    // R9 wake mask and halted gating
    halted = 1'b1;
    pin_in[0] = 1'b1;
    wake_count(n);
    chk("R9 masked pin wakes", 128'(n), 128'd1);
    pin_in[2] = 1'b0;
    wake_count(n);
    chk("R9 unmasked pin no wake", 128'(n), 128'd0);
    halted = 1'b0;
    pin_in[0] = 1'b0;
    wake_count(n);
    chk("R9 not halted no wake", 128'(n), 128'd0);
    wr(10'h048, 32'h3);
    // R10 out-of-range offsets
    wr(10'h200, 32'hFFFFFFFF);
    wr(10'h30C, 32'hFFFFFFFF);
    rd_exp("R10 read high alias", 10'h30C, 32'h0);
    rd_exp("R10 dir3 untouched", 10'h10C, 32'h12345678);
    rd_exp("R10 read top", 10'h3FC, 32'h0);
    // R11 strobe only on level reads
    rd(10'h100, d, s);
    chk("R11 strobe on level read", 128'(s), 128'h1);
    rd(10'h00C, d, s);
    chk("R11 no strobe on dir read", 128'(s), 128'h0);
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(99, 0));
      if ($urandom_range(3, 0) == 0) begin
        int p;
        p = int'($urandom_range(127, 0));
        pin_in[p] = ~pin_in[p];
      end
      halted = ($urandom_range(7, 0) == 0);
      if (op < 30) begin
        bus_rd = 1;
        bus_addr = (op < 22) ? addr_of(int'($urandom_range(8, 0)), int'($urandom_range(3, 0)))
                             : 10'($urandom_range(1023, 0));
      end else if (op < 50) begin
        bus_wr = 1;
        bus_addr = (op < 46) ? addr_of(int'($urandom_range(8, 0)), int'($urandom_range(3, 0)))
                             : 10'($urandom_range(1023, 0));
        bus_wdata = $urandom;
      end
      @(negedge clk);
      bus_rd = 0;
      bus_wr = 0;
    end
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule